// File: doc/BRIEF.md
# Multi-Line DMA Transmit Scanner

This block is the transmit half of a sixteen-line serial multiplexer. Software programs each line through one shared register window. A line-select field in the control/status register decides which line's 18-bit memory address and 16-bit byte count a register access reaches. Software loads a count as the negative of the number of bytes to send, then sets that line's bit in the active bitmap.

The scanner serves the active lines round-robin. In each cycle it picks at most one line whose serializer reports ready. It reads one byte from a single-cycle memory port at that line's address and hands the byte to the line. It then advances the line's address and count. The byte that brings the count to zero ends the transfer. The line's active bit then drops and a shared done flag rises, which can raise an interrupt. A per-line break bitmap and a loopback enable pass straight to the serializers.

Register offsets are: 0 control/status, 1 address, 2 count, 3 active bitmap, 4 break bitmap. A read returns on `cfg_rdata` one cycle after `cfg_addr` is presented.

Top module: `txscan_top`

## Requirements
- R1: After reset every register reads zero, `tx_valid`, `brk_line`, `loop_en` and `tx_irq` are low.
- R2: Control/status bits 3:0 select the line; writes and reads at offset 1 (address bits 15:0) and offset 2 (count) reach only that line; an address write takes control/status bits 5:4 as address bits 17:16.
- R3: A byte hand-off drives `mem_addr` with the line's 18-bit address, passes `mem_rdata` to `tx_data` with that line's `tx_valid` bit high in the same cycle, and then increments the line's address and count by one.
- R4: The hand-off that brings a line's count to zero clears that line's bit in the active bitmap (offset 3) and sets the done flag, control/status bit 15.
- R5: Eligible lines are granted in rotating order starting after the most recently granted line.
- R6: At most one `tx_valid` bit is high per cycle, and only for a line that is active and whose `tx_ready` is high.
- R7: Writing 1s to the active bitmap sets those bits; writing 0s leaves bits unchanged.
- R8: Writing a count of 0xFFFF to a line mid-transfer lets exactly one more byte go before that line stops.
- R9: A control/status write with bit 15 at 0 clears the done flag and a write with bit 15 at 1 leaves it unchanged; a completion in the same cycle as a clearing write leaves the flag set.
- R10: `tx_irq` is high exactly when the done flag and the interrupt enable (control/status bit 6) are both set.
- R11: The break bitmap (offset 4) drives `brk_line` bit for bit, and control/status bit 9 drives `loop_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, one cycle after `cfg_addr` |
| mem_addr | output | 18 | Byte read address |
| mem_rdata | input | 8 | Byte read data, same cycle |
| tx_valid | output | 16 | Per-line byte strobe |
| tx_ready | input | 16 | Per-line serializer ready |
| tx_data | output | 8 | Byte handed to the strobed line |
| brk_line | output | 16 | Per-line force-spacing control |
| loop_en | output | 1 | Maintenance loopback enable |
| tx_irq | output | 1 | Transmit-done interrupt |

## Verification
A transfer can complete in the same cycle that software writes the control/status register with the done bit at 0. The bench holds a one-byte transfer back by keeping that line's ready low. It then raises ready on the same falling edge that starts the clearing write. Reading back afterwards must show the done flag still set, and a second clearing write must then drop it. The count truncation is also aligned by holding ready low while the 0xFFFF write lands, and exactly one further byte must follow.

// File: rtl/txscan_pkg.sv
package txscan_pkg;
  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_ADDR  = 3'd1,
    OFS_COUNT = 3'd2,
    OFS_ACT   = 3'd3,
    OFS_BRK   = 3'd4
  } reg_ofs_e;

  localparam int CTRL_DONE_BIT = 15;
  localparam int CTRL_LOOP_BIT = 9;
  localparam int CTRL_IE_BIT   = 6;
  localparam int CTRL_EXT_LSB  = 4;
  localparam int REG_W         = 16;
endpackage

// File: rtl/txscan_rr_arb.sv
module txscan_rr_arb #(
  parameter int LINES = 16,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req,
  output logic             gnt_v,
  output logic [IW-1:0]    gnt_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt_v   = 1'b0;
    gnt_idx = ptr_q;
    for (int i = 0; i < LINES; i++) begin
      int k;
      k = (int'(ptr_q) + i) % LINES;
      if (!gnt_v && req[k]) begin
        gnt_v   = 1'b1;
        gnt_idx = IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (gnt_v) ptr_q <= (int'(gnt_idx) == LINES-1) ? '0 : gnt_idx + 1'b1;
  end

  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (rst)
    gnt_v |-> req[gnt_idx]); // R6
endmodule

// File: rtl/txscan_line_regs.sv
module txscan_line_regs #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16,
  localparam int IW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     sw_sel,
  input  logic              sw_addr_we,
  input  logic [ADDR_W-1:0] sw_addr_val,
  input  logic              sw_cnt_we,
  input  logic [CNT_W-1:0]  sw_cnt_val,
  input  logic              adv,
  input  logic [IW-1:0]     adv_sel,
  output logic [ADDR_W-1:0] adv_addr,
  output logic              adv_last,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [CNT_W-1:0]  sel_cnt
);
  logic [ADDR_W-1:0] addr_q [LINES];
  logic [CNT_W-1:0]  cnt_q  [LINES];

  assign adv_addr = addr_q[adv_sel];
  assign adv_last = (cnt_q[adv_sel] == {CNT_W{1'b1}});
  assign sel_addr = addr_q[sw_sel];
  assign sel_cnt  = cnt_q[sw_sel];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else begin
        if (sw_addr_we && int'(sw_sel) == g) addr_q[g] <= sw_addr_val;
        else if (adv && int'(adv_sel) == g) addr_q[g] <= addr_q[g] + 1'b1;
        if (sw_cnt_we && int'(sw_sel) == g) cnt_q[g] <= sw_cnt_val;
        else if (adv && int'(adv_sel) == g) cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !(sw_cnt_we && sw_sel == adv_sel))
      |=> cnt_q[$past(adv_sel)] == $past(cnt_q[adv_sel]) + 1'b1); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !(sw_addr_we && sw_sel == adv_sel))
      |=> addr_q[$past(adv_sel)] == $past(addr_q[adv_sel]) + 1'b1); // R3
endmodule

// File: rtl/txscan_top.sv
module txscan_top
  import txscan_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16,
  localparam int IW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [LINES-1:0]  tx_valid,
  input  logic [LINES-1:0]  tx_ready,
  output logic [7:0]        tx_data,
  output logic [LINES-1:0]  brk_line,
  output logic              loop_en,
  output logic              tx_irq
);
  localparam int EXT_W = ADDR_W - REG_W;

  logic [IW-1:0]    sel_q;
  logic [EXT_W-1:0] ext_q;
  logic             ie_q, loop_q, done_q;
  logic [LINES-1:0] act_q, brk_q;

  logic wr_ctrl, wr_addr, wr_cnt, wr_act, wr_brk;
  assign wr_ctrl = cfg_wr && cfg_addr == OFS_CTRL;
  assign wr_addr = cfg_wr && cfg_addr == OFS_ADDR;
  assign wr_cnt  = cfg_wr && cfg_addr == OFS_COUNT;
  assign wr_act  = cfg_wr && cfg_addr == OFS_ACT;
  assign wr_brk  = cfg_wr && cfg_addr == OFS_BRK;

  logic             gnt_v;
  logic [IW-1:0]    gnt_idx;
  logic             last_byte, fin;
  logic [ADDR_W-1:0] sel_addr;
  logic [CNT_W-1:0]  sel_cnt;
  logic [LINES-1:0]  gnt_mask, set_mask;

  txscan_rr_arb #(.LINES(LINES)) u_arb (
    .clk(clk), .rst(rst), .req(act_q & tx_ready),
    .gnt_v(gnt_v), .gnt_idx(gnt_idx)
  );

  txscan_line_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .sw_sel(sel_q),
    .sw_addr_we(wr_addr), .sw_addr_val({ext_q, cfg_wdata}),
    .sw_cnt_we(wr_cnt),   .sw_cnt_val(cfg_wdata[CNT_W-1:0]),
    .adv(gnt_v), .adv_sel(gnt_idx),
    .adv_addr(mem_addr), .adv_last(last_byte),
    .sel_addr(sel_addr), .sel_cnt(sel_cnt)
  );

  assign gnt_mask = LINES'(1) << gnt_idx;
  assign set_mask = wr_act ? cfg_wdata[LINES-1:0] : '0;
  assign fin      = gnt_v && last_byte;
  assign tx_valid = gnt_v ? gnt_mask : '0;
  assign tx_data  = mem_rdata;
  assign brk_line = brk_q;
  assign loop_en  = loop_q;
  assign tx_irq   = done_q && ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ext_q  <= '0;
      ie_q   <= 1'b0;
      loop_q <= 1'b0;
      done_q <= 1'b0;
      act_q  <= '0;
      brk_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= cfg_wdata[IW-1:0];
        ext_q  <= cfg_wdata[CTRL_EXT_LSB +: EXT_W];
        ie_q   <= cfg_wdata[CTRL_IE_BIT];
        loop_q <= cfg_wdata[CTRL_LOOP_BIT];
      end
      done_q <= ((wr_ctrl ? cfg_wdata[CTRL_DONE_BIT] : 1'b1) && done_q) || fin;
      act_q  <= (act_q & ~(fin ? gnt_mask : '0)) | set_mask;
      if (wr_brk) brk_q <= cfg_wdata[LINES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      unique case (cfg_addr)
        OFS_CTRL:  cfg_rdata <= {done_q, 5'b0, loop_q, 2'b0, ie_q, ext_q, 4'(sel_q)};
        OFS_ADDR:  cfg_rdata <= sel_addr[REG_W-1:0];
        OFS_COUNT: cfg_rdata <= REG_W'(sel_cnt);
        OFS_ACT:   cfg_rdata <= REG_W'(act_q);
        OFS_BRK:   cfg_rdata <= REG_W'(brk_q);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  AST_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_valid)); // R6
  AST_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    (tx_valid & ~tx_ready) == '0); // R6
  AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (tx_valid & ~act_q) == '0); // R6
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    fin |=> done_q); // R9
  AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fin && !set_mask[gnt_idx]) |=> !act_q[$past(gnt_idx)]); // R4
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> done_q); // R10
endmodule

// File: tb/test_txscan_top.sv
module test_txscan_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic [17:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [15:0] tx_valid;
  logic [15:0] tx_ready = 16'hFFFF;
  logic [7:0]  tx_data;
  logic [15:0] brk_line;
  logic        loop_en;
  logic        tx_irq;

  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] mem_f(logic [17:0] a);
    return a[7:0] ^ {a[17:16], a[13:8]};
  endfunction
  assign mem_rdata = mem_f(mem_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  txscan_top i_txscan_top (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .brk_line(brk_line), .loop_en(loop_en), .tx_irq(tx_irq)
  );

  int          log_n = 0;
  int          log_line [0:511];
  logic [17:0] log_addr [0:511];
  logic [7:0]  log_data [0:511];

  always @(posedge clk) begin
    if (!rst && tx_valid != 16'd0 && log_n < 512) begin
      for (int i = 0; i < LINES; i++) if (tx_valid[i]) log_line[log_n] = i;
      log_addr[log_n] = mem_addr;
      log_data[log_n] = tx_data;
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1", "tx_valid", tx_valid, 0);
    check("R1", "brk_line", brk_line, 0);
    check("R1", "loop_en", loop_en, 0);
    check("R1", "tx_irq", tx_irq, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1", "register", v, 0);
    end
  endtask

  task automatic t_single;
    logic [15:0] v;
    int base;
    // line 3, ext bits 5:4 = 1, interrupt enable bit 6
    wr(3'd0, 16'h0053);
    wr(3'd1, 16'h0100);
    wr(3'd2, 16'hFFFC);
    base = log_n;
    wr(3'd3, 16'h0008);
    idle(8);
    check("R3", "byte count", log_n - base, 4);
    for (int k = 0; k < 4; k++) begin
      check("R3", "line", log_line[base+k], 3);
      check("R3", "address", log_addr[base+k], 18'h10100 + k);
      check("R3", "data", log_data[base+k], mem_f(18'h10100 + 18'(k)));
    end
    rd(3'd3, v); check("R4", "active cleared", v, 16'h0000);
    rd(3'd0, v); check("R4", "done flag", v[15], 1);
    check("R10", "irq", tx_irq, 1);
    rd(3'd1, v); check("R2", "address advanced", v, 16'h0104);
    rd(3'd2, v); check("R3", "count reached zero", v, 16'h0000);
  endtask

  task automatic t_select;
    logic [15:0] v;
    wr(3'd0, 16'h0046); wr(3'd1, 16'h1234); wr(3'd2, 16'h0077);
    wr(3'd0, 16'h0048); wr(3'd1, 16'hABCD);
    rd(3'd1, v); check("R2", "line 8 address", v, 16'hABCD);
    rd(3'd2, v); check("R2", "line 8 count", v, 16'h0000);
    wr(3'd0, 16'h0046);
    rd(3'd1, v); check("R2", "line 6 address", v, 16'h1234);
    rd(3'd2, v); check("R2", "line 6 count", v, 16'h0077);
  endtask

  task automatic t_round_robin;
    int base;
    int exp_order [3] = '{5, 9, 0};
    wr(3'd0, 16'h0040); wr(3'd1, 16'h2000); wr(3'd2, 16'hFFFD);
    wr(3'd0, 16'h0045); wr(3'd1, 16'h3000); wr(3'd2, 16'hFFFD);
    wr(3'd0, 16'h0049); wr(3'd1, 16'h4000); wr(3'd2, 16'hFFFD);
    base = log_n;
    wr(3'd3, 16'h0221);
    idle(14);
    check("R5", "total bytes", log_n - base, 9);
    for (int k = 0; k < 9; k++)
      check("R5", "grant order", log_line[base+k], exp_order[k%3]);
  endtask

  task automatic t_ready_gate;
    logic [15:0] v;
    int base;
    tx_ready = 16'hFFFB;
    wr(3'd0, 16'h0042); wr(3'd1, 16'h0500); wr(3'd2, 16'hFFFE);
    base = log_n;
    wr(3'd3, 16'h0004);
    idle(8);
    check("R6", "no byte while not ready", log_n - base, 0);
    wr(3'd3, 16'h0000);
    rd(3'd3, v); check("R7", "zero write keeps active", v, 16'h0004);
    tx_ready = 16'hFFFF;
    idle(6);
    check("R6", "bytes after ready", log_n - base, 2);
  endtask

  task automatic t_truncate;
    logic [15:0] v;
    int base;
    wr(3'd0, 16'h0047); wr(3'd1, 16'h0600); wr(3'd2, 16'hFF9C);
    wr(3'd3, 16'h0080);
    idle(4);
    tx_ready = 16'hFF7F;
    idle(2);
    base = log_n;
    wr(3'd2, 16'hFFFF);
    tx_ready = 16'hFFFF;
    idle(6);
    check("R8", "bytes after truncation", log_n - base, 1);
    rd(3'd3, v); check("R8", "line stopped", v[7], 0);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    wr(3'd0, 16'h0041);
    rd(3'd0, v); check("R9", "done cleared first", v[15], 0);
    tx_ready = 16'hFFFD;
    wr(3'd1, 16'h0700); wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0002);
    idle(3);
    // completion and clearing write fall on the same edge
    @(negedge clk);
    tx_ready = 16'hFFFF;
    cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'h0041;
    @(negedge clk);
    cfg_wr = 1'b0;
    rd(3'd0, v); check("R9", "completion wins over clear", v[15], 1);
    check("R10", "irq with enable", tx_irq, 1);
    wr(3'd0, 16'h8001);
    check("R10", "irq without enable", tx_irq, 0);
    rd(3'd0, v); check("R9", "writing 1 keeps done", v[15], 1);
    wr(3'd0, 16'h0041);
    rd(3'd0, v); check("R9", "clear by zero", v[15], 0);
    wr(3'd0, 16'h8041);
    rd(3'd0, v); check("R9", "writing 1 does not set", v[15], 0);
    check("R10", "irq low after clear", tx_irq, 0);
  endtask

  task automatic t_break_loop;
    logic [15:0] v;
    wr(3'd4, 16'hA5C3);
    check("R11", "break lines", brk_line, 16'hA5C3);
    rd(3'd4, v); check("R11", "break readback", v, 16'hA5C3);
    wr(3'd0, 16'h0200);
    check("R11", "loopback on", loop_en, 1);
    wr(3'd0, 16'h0000);
    check("R11", "loopback off", loop_en, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_select();
    t_round_robin();
    t_ready_gate();
    t_truncate();
    t_collision();
    t_break_loop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule